// File: doc/BRIEF.md
# NAND Ready Wait Controller

This block holds a flash interface until a NAND device has finished a program or an erase. It sits between a sequencer that issues the operation and a simple command/data bus toward the flash. One strap input picks between two ways of learning that the device is ready.

In status-poll mode (no ready/busy wire on the board), the block first waits a fixed settling delay of `SETTLE_US` microseconds. It then writes the status-read command once and reads status bytes back until one of them shows the ready bit. If an operation-dependent time limit runs out first, it gives up and reports the last byte it read. The limit is 400 ms for an erase and 20 ms for anything else. In ready-line mode, it watches a latched ready event in a wider interrupt-status word. When it finds the event set, it acknowledges it by writing that bit back as one. If the event stays clear, it re-checks a bounded number of times and then reports not-ready.

Each operation ends with a one-cycle `done` pulse. `status` and `timedOut` then hold their values until the next accepted start.

Top module: `nand_ready_wait`

## Requirements
- R1: After reset the block is idle: `done`, `cmdWr`, `rdReq`, `irqClrWr` and `timedOut` are 0, and `status` is 0x01.
- R2: In status-poll mode (`modeReadyLine`=0), `cmdWr` is asserted for exactly one cycle with `cmdByte`=0x70, exactly SETTLE_CYC cycles after the start is accepted (SETTLE_CYC = ceil(CLK_HZ*SETTLE_US/1e6)). No read is requested before that cycle.
- R3: After the command, every cycle with `rdReq` and `rdAck` high is one status read. Polling stops at the first byte whose bit 6 is 1. `done` follows in the next cycle with `status` equal to that byte and `timedOut`=0.
- R4: The time limit runs from the accepted start: ERASE_MS milliseconds when `opErase`=1 and PROG_MS milliseconds when it is 0. A millisecond is CLK_HZ/1000 cycles. When the limit expires without a ready byte, `done` is pulsed with `timedOut`=1 and `status` equal to the last byte read.
- R5: If no read is acknowledged before the limit expires, `status` at `done` is the failure default 0x01.
- R6: In ready-line mode, the block checks bit 8 of `irqStat` once per cycle. When the bit is 1, it pulses `irqClrWr` for one cycle with `irqClrData` equal to `irqStat` with bit 8 forced to 1. `done` follows in the next cycle with `timedOut`=0. In this mode no status command is written.
- R7: In ready-line mode, if bit 8 is still 0 after the first check plus MAX_RECHECK (default 0x1FF) re-checks, `done` is pulsed with `timedOut`=1. In this case no clear write is made.
- R8: `done` is high for exactly one cycle per operation. `status` and `timedOut` hold after `done` until the next start. The time limit is reloaded on every start.
- R9: A `start` pulse while an operation is in progress is ignored: it produces no extra command, read or `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a wait (accepted only when idle) |
| opErase | input | 1 | 1: erase limit, 0: program/other limit |
| modeReadyLine | input | 1 | 1: ready-line mode, 0: status-poll mode |
| cmdWr | output | 1 | Command-latch write strobe |
| cmdByte | output | 8 | Command byte (status read, 0x70) |
| rdReq | output | 1 | Data-path read request |
| rdAck | input | 1 | Read completes this cycle |
| rdData | input | 8 | Status byte returned by the read |
| irqStat | input | IRQ_W | Interrupt status word, ready event at bit 8 |
| irqClrWr | output | 1 | Write-one-to-clear strobe for the interrupt status |
| irqClrData | output | IRQ_W | Value written with `irqClrWr` |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Last status byte, 0x01 if none |
| timedOut | output | 1 | Limit expired before ready was seen |

## Verification
The bench builds the block with CLK_HZ=100000. This makes a millisecond 100 cycles and the settling delay 5 cycles. Both the 20 ms program limit (2000 cycles) and the 400 ms erase limit (40000 cycles) can then be reached and timed exactly, as can the delay between start and the status command. MAX_RECHECK keeps its default of 0x1FF, so the full bound of 512 ready-line checks is exercised.

// File: rtl/nrw_pkg.sv
package nrw_pkg;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam int STAT_READY_BIT = 6;
  localparam logic [7:0] STAT_FAIL_DEFAULT = 8'h01;
  localparam int IRQ_READY_BIT = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_CMD, ST_POLL, ST_LINE, ST_FIN
  } nrwState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startLoad;
    logic latchStat;
    logic incWait;
    logic flagTimeout;
  } nrwStrobe_t;
endpackage

// File: rtl/nrw_datapath.sv
module nrw_datapath
  import nrw_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int ERASE_MS = 400,
  parameter int PROG_MS = 20,
  parameter int SETTLE_CYC = 5000,
  parameter int MAX_RECHECK = 511
) (
  input  logic       clk,
  input  logic       rstN,
  input  nrwStrobe_t strb,
  input  logic       opErase,
  input  logic       timerRun,
  input  logic [7:0] rdData,
  output logic       expired,
  output logic       settleDone,
  output logic       checksDone,
  output logic [7:0] status,
  output logic       timedOut
);
  localparam int TICK_CYC = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int MS_MAX = (ERASE_MS > PROG_MS) ? ERASE_MS : PROG_MS;
  localparam int WAIT_MAX = (SETTLE_CYC > MAX_RECHECK) ? SETTLE_CYC : MAX_RECHECK;
  localparam int SETTLE_LAST = (SETTLE_CYC > 0) ? SETTLE_CYC - 1 : 0;
  localparam int TW = $clog2(TICK_CYC + 1);
  localparam int MW = $clog2(MS_MAX + 1);
  localparam int WW = $clog2(WAIT_MAX + 1);

  logic          isErase;
  logic [TW-1:0] tickCnt;
  logic [MW-1:0] msCnt;
  logic [MW-1:0] limitMs;
  logic [WW-1:0] waitCnt;
  logic [7:0]    statReg;
  logic          toReg;

  assign limitMs    = isErase ? MW'(ERASE_MS) : MW'(PROG_MS);
  assign expired    = (msCnt >= limitMs);
  assign settleDone = (waitCnt == WW'(SETTLE_LAST));
  assign checksDone = (waitCnt == WW'(MAX_RECHECK));
  assign status     = statReg;
  assign timedOut   = toReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isErase <= 1'b0;
      tickCnt <= '0;
      msCnt   <= '0;
      waitCnt <= '0;
      statReg <= STAT_FAIL_DEFAULT;
      toReg   <= 1'b0;
    end else if (strb.startLoad) begin
      isErase <= opErase;
      tickCnt <= '0;
      msCnt   <= '0;
      waitCnt <= '0;
      statReg <= STAT_FAIL_DEFAULT;
      toReg   <= 1'b0;
    end else begin
      if (timerRun && !expired) begin
        if (tickCnt == TW'(TICK_CYC - 1)) begin
          tickCnt <= '0;
          msCnt   <= msCnt + MW'(1);
        end else begin
          tickCnt <= tickCnt + TW'(1);
        end
      end
      if (strb.incWait)     waitCnt <= waitCnt + WW'(1);
      if (strb.latchStat)   statReg <= rdData;
      if (strb.flagTimeout) toReg   <= 1'b1;
    end
  end
endmodule

// File: rtl/nrw_control.sv
module nrw_control
  import nrw_pkg::*;
#(
  parameter bit HAS_SETTLE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       modeReadyLine,
  input  logic       rdAck,
  input  logic       pollReady,
  input  logic       irqReady,
  input  logic       expired,
  input  logic       settleDone,
  input  logic       checksDone,
  output nrwStrobe_t strb,
  output logic       cmdWr,
  output logic       rdReq,
  output logic       irqClrWr,
  output logic       done,
  output logic       timerRun
);
  nrwState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt      = state;
    strb     = '0;
    cmdWr    = 1'b0;
    rdReq    = 1'b0;
    irqClrWr = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.startLoad = 1'b1;
          if (modeReadyLine) nxt = ST_LINE;
          else if (HAS_SETTLE) nxt = ST_SETTLE;
          else nxt = ST_CMD;
        end
      end
      ST_SETTLE: begin
        strb.incWait = 1'b1;
        if (settleDone) nxt = ST_CMD;
      end
      ST_CMD: begin
        cmdWr = 1'b1;
        nxt   = ST_POLL;
      end
      ST_POLL: begin
        rdReq = 1'b1;
        if (rdAck) begin
          strb.latchStat = 1'b1;
          if (pollReady) begin
            nxt = ST_FIN;
          end else if (expired) begin
            strb.flagTimeout = 1'b1;
            nxt = ST_FIN;
          end
        end else if (expired) begin
          strb.flagTimeout = 1'b1;
          nxt = ST_FIN;
        end
      end
      ST_LINE: begin
        if (irqReady) begin
          irqClrWr = 1'b1;
          nxt = ST_FIN;
        end else if (checksDone) begin
          strb.flagTimeout = 1'b1;
          nxt = ST_FIN;
        end else begin
          strb.incWait = 1'b1;
        end
      end
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign done     = (state == ST_FIN);
  assign timerRun = (state != ST_IDLE) && (state != ST_FIN);
endmodule

// File: rtl/nand_ready_wait.sv
module nand_ready_wait
  import nrw_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int ERASE_MS = 400,
  parameter int PROG_MS = 20,
  parameter int SETTLE_US = 50,
  parameter int MAX_RECHECK = 511,
  parameter int IRQ_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             opErase,
  input  logic             modeReadyLine,
  output logic             cmdWr,
  output logic [7:0]       cmdByte,
  output logic             rdReq,
  input  logic             rdAck,
  input  logic [7:0]       rdData,
  input  logic [IRQ_W-1:0] irqStat,
  output logic             irqClrWr,
  output logic [IRQ_W-1:0] irqClrData,
  output logic             done,
  output logic [7:0]       status,
  output logic             timedOut
);
  localparam longint SETTLE_RAW =
    (longint'(CLK_HZ) * longint'(SETTLE_US) + 64'd999_999) / 64'd1_000_000;
  localparam int SETTLE_CYC = int'(SETTLE_RAW);

  nrwStrobe_t strb;
  logic expired, settleDone, checksDone, timerRun;

  nrw_control #(.HAS_SETTLE(SETTLE_CYC > 0)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .modeReadyLine(modeReadyLine),
    .rdAck(rdAck), .pollReady(rdData[STAT_READY_BIT]),
    .irqReady(irqStat[IRQ_READY_BIT]), .expired(expired),
    .settleDone(settleDone), .checksDone(checksDone), .strb(strb),
    .cmdWr(cmdWr), .rdReq(rdReq), .irqClrWr(irqClrWr), .done(done),
    .timerRun(timerRun)
  );

  nrw_datapath #(
    .CLK_HZ(CLK_HZ), .ERASE_MS(ERASE_MS), .PROG_MS(PROG_MS),
    .SETTLE_CYC(SETTLE_CYC), .MAX_RECHECK(MAX_RECHECK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opErase(opErase),
    .timerRun(timerRun), .rdData(rdData), .expired(expired),
    .settleDone(settleDone), .checksDone(checksDone), .status(status),
    .timedOut(timedOut)
  );

  assign cmdByte    = CMD_READ_STATUS;
  assign irqClrData = irqStat | (IRQ_W'(1) << IRQ_READY_BIT);
endmodule

// File: rtl/nrw_checker.sv
module nrw_checker #(
  parameter int IRQ_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdWr,
  input logic [7:0]       cmdByte,
  input logic             rdReq,
  input logic [IRQ_W-1:0] irqStat,
  input logic             irqClrWr,
  input logic [IRQ_W-1:0] irqClrData,
  input logic             done,
  input logic             timedOut
);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_cmd_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr |-> (cmdByte == 8'h70));

  p_cmd_alone_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr |-> (!rdReq && !irqClrWr));

  p_clr_value_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqClrWr |-> (irqStat[8] && irqClrData[8] && irqClrData[7:0] == irqStat[7:0]));

  p_clr_then_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqClrWr |=> (done && !timedOut));

  p_timeout_at_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timedOut) |-> done);
endmodule

bind nand_ready_wait nrw_checker #(.IRQ_W(IRQ_W)) u_chk (.*);

// File: tb/nand_ready_wait_test.sv
module nand_ready_wait_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 5;
  localparam int TICK = 100;

  typedef struct {
    logic [7:0] st;
    bit         to;
    int         delta;
    int         cmdN;
    int         clrN;
    string      tag;
  } exp_t;

  logic clk = 0, rstN = 0, start = 0, opErase = 0, modeReadyLine = 0;
  logic cmdWr, rdReq, rdAck, irqClrWr, done, timedOut;
  logic [7:0] cmdByte, rdData, status;
  logic [15:0] irqStat, irqClrData;

  nand_ready_wait #(.CLK_HZ(100_000)) uut (
    .clk(clk), .rstN(rstN), .start(start), .opErase(opErase),
    .modeReadyLine(modeReadyLine), .cmdWr(cmdWr), .cmdByte(cmdByte),
    .rdReq(rdReq), .rdAck(rdAck), .rdData(rdData), .irqStat(irqStat),
    .irqClrWr(irqClrWr), .irqClrData(irqClrData), .done(done),
    .status(status), .timedOut(timedOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // flash and interrupt model
  int cyc = 0, readsTotal = 0, baseReads = 0, readyAfter = 0, irqAt = -1;
  logic [7:0] busyByte = 8'h80, readyByte = 8'h40;
  logic ackOn = 1, irqFlag = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rdReq && rdAck) readsTotal <= readsTotal + 1;
    if (irqClrWr && irqClrData[8]) irqFlag <= 1'b0;
    else if (cyc == irqAt) irqFlag <= 1'b1;
  end
  assign rdAck   = rdReq & ackOn;
  assign rdData  = ((readsTotal - baseReads) >= readyAfter) ? readyByte : busyByte;
  assign irqStat = {7'b0, irqFlag, 8'h02};

  exp_t sbq[$];
  int nChecks = 0, nFail = 0;
  int startCyc = 0, cmdBase = 0, clrBase = 0, cmdN = 0, clrN = 0, cmdCyc = 0;
  bit prevDone = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic monitor();
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (cmdWr) begin cmdN++; cmdCyc = cyc; end
        if (irqClrWr) begin
          clrN++;
          chk(irqClrData == 16'h0102, "R6", "clear data", irqClrData, 16'h0102);
        end
        if (done) begin
          chk(!prevDone, "R8", "done longer than one cycle", 1, 0);
          if (sbq.size() == 0) begin
            chk(0, "R9", "unexpected done", 1, 0);
          end else begin
            exp_t e = sbq.pop_front();
            int d = cyc - startCyc;
            chk(status == e.st, e.tag, "status", status, e.st);
            chk(timedOut == e.to, e.tag, "timedOut", timedOut, e.to);
            chk(d >= e.delta - 1 && d <= e.delta + 1, e.tag, "done delay", d, e.delta);
            chk(cmdN - cmdBase == e.cmdN, e.tag, "command writes", cmdN - cmdBase, e.cmdN);
            chk(clrN - clrBase == e.clrN, e.tag, "clear writes", clrN - clrBase, e.clrN);
            if (e.cmdN == 1)
              chk(cmdCyc - startCyc == SETTLE, "R2", "command delay",
                  cmdCyc - startCyc, SETTLE);
          end
        end
        prevDone = done;
      end
    end
  endtask

  task automatic runOp(input bit lineMode, input bit erase, input int rdyAfter,
                       input logic [7:0] rdyByte, input bit ack, input int irqDelay,
                       input logic [7:0] expSt, input bit expTo, input int expDelta,
                       input int expCmd, input int expClr, input string tag,
                       input bit doubleStart);
    exp_t e;
    modeReadyLine = lineMode;
    opErase = erase;
    readyAfter = rdyAfter;
    readyByte = rdyByte;
    ackOn = ack;
    irqAt = -1;
    if (irqDelay == 0) begin
      irqAt = cyc;
      repeat (2) @(negedge clk);
    end
    @(negedge clk);
    e.st = expSt; e.to = expTo; e.delta = expDelta;
    e.cmdN = expCmd; e.clrN = expClr; e.tag = tag;
    sbq.push_back(e);
    cmdBase = cmdN; clrBase = clrN; baseReads = readsTotal;
    start = 1;
    @(negedge clk);
    start = 0;
    startCyc = cyc;
    if (irqDelay > 0) irqAt = startCyc + irqDelay - 2;
    if (doubleStart) begin
      repeat (2) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (sbq.size() != 0) @(negedge clk);
    repeat (doubleStart ? 20 : 3) @(negedge clk);
    chk(status == expSt && !done, "R8", "status hold after done", status, expSt);
    chk(timedOut == expTo, "R8", "timedOut hold after done", timedOut, expTo);
  endtask

  initial begin
    fork
      monitor();
      begin
        repeat (150_000) @(posedge clk);
        nFail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    chk(!done && !cmdWr && !rdReq && !irqClrWr, "R1", "idle strobes", done, 0);
    chk(!timedOut, "R1", "timedOut", timedOut, 0);
    chk(status == 8'h01, "R1", "status", status, 8'h01);

    // R2 R3: ready on the first read
    runOp(0, 0, 0, 8'h40, 1, -1, 8'h40, 0, SETTLE + 2, 1, 0, "R3", 0);
    // R3: three busy reads then ready with fail bit
    runOp(0, 0, 3, 8'h41, 1, -1, 8'h41, 0, SETTLE + 5, 1, 0, "R3", 0);
    // R4: program limit, never ready, last byte returned
    runOp(0, 0, 1 << 30, 8'h40, 1, -1, 8'h80, 1, 20 * TICK + 1, 1, 0, "R4", 0);
    // R4: erase limit
    runOp(0, 1, 1 << 30, 8'h40, 1, -1, 8'h80, 1, 400 * TICK + 1, 1, 0, "R4", 0);
    // R5: no read acknowledged, default failure status; limit reloaded (R8)
    runOp(0, 0, 0, 8'h40, 0, -1, 8'h01, 1, 20 * TICK + 1, 1, 0, "R5", 0);
    // R6: ready event already set
    runOp(1, 0, 0, 8'h40, 1, 0, 8'h01, 0, 1, 0, 1, "R6", 0);
    // R6: ready event appears later
    runOp(1, 0, 0, 8'h40, 1, 50, 8'h01, 0, 50, 0, 1, "R6", 0);
    // R7: ready event never appears
    runOp(1, 0, 0, 8'h40, 1, -1, 8'h01, 1, 513, 0, 0, "R7", 0);
    // R9: second start while busy is ignored
    runOp(0, 0, 3, 8'h41, 1, -1, 8'h41, 0, SETTLE + 5, 1, 0, "R9", 1);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule